// File: doc/BRIEF.md
# Transparent Serial Word Receiver

This block takes a bit-serial stream of transparent data and packs it into 16-bit words. A bit is accepted on a clock edge only when the receiver is enabled and the data-valid qualifier is high. Every word is filled completely with received bits, and the earliest bit lands in the most significant position. Bits from an incomplete word stay in the shift register until more valid bits arrive, so frames that are not a multiple of 16 bits leave a residue behind.

Finished words wait in a small FIFO. Whenever the FIFO holds at least one word, the block asks for service. When the grant input is high, the word at the head is written to the receive buffer named by the descriptor inputs, one full word per write. A buffer closes when its byte count reaches the programmed maximum length. The descriptor source then moves on to the next buffer.

Two faults are recorded: a word that finds the FIFO full, and a word that is ready to store when no buffer is available. These, together with the buffer-closed and word-stored events, set sticky event bits. Software clears an event bit by writing a one to it. An interrupt line combines the event bits with a mask.

Top module: `tsr_rx`

## Requirements
- R1: A bit is shifted in only on a clock edge where rx_en and rx_valid are both high. While rx_en is low, incoming bits are ignored and the count of partly received bits returns to zero.
- R2: A word is complete after 16 accepted bits. The first accepted bit is bit 15 of the word. Fewer than 16 pending bits never produce a word.
- R3: Each stored word is written with mem_addr equal to desc_addr plus twice the index of that word in the current buffer. desc_addr and max_len are even.
- R4: desc_done pulses together with the write that brings the buffer's byte count (2 × words written) to max_len. The next write starts again at index 0.
- R5: The FIFO holds at most three words. svc_req is high exactly when it holds one or more words. A word is removed when mem_grant is high and svc_req is high.
- R6: A word that completes while the FIFO holds three words and no word leaves it in that cycle is discarded and sets the overrun event. A word that completes in the same cycle as a removal from a full FIFO is kept.
- R7: A removed word is written (mem_wr high) only when desc_ready is high. A removal while desc_ready is low discards the word and sets the busy event.
- R8: ev bit 0 is set when a buffer closes while desc_intr is high. Bit 1 is set for every stored word, bit 2 for busy and bit 3 for overrun. Each bit is visible from the cycle after its cause. A one in ev_clr clears that bit, and a new setting of the bit in the same cycle takes priority over the clear.
- R9: irq is high exactly when some bit of ev and the same bit of ev_mask are both one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| rx_valid | input | 1 | Data-valid qualifier for rx_bit |
| rx_bit | input | 1 | Serial data bit |
| max_len | input | LW | Buffer length in bytes (even) |
| desc_ready | input | 1 | Current receive buffer is available |
| desc_intr | input | 1 | Current buffer requests an event on close |
| desc_addr | input | AW | Byte start address of current buffer (even) |
| desc_done | output | 1 | Current buffer closed on this write |
| svc_req | output | 1 | FIFO holds at least one word |
| mem_grant | input | 1 | Permission to remove the head word |
| mem_wr | output | 1 | Word write strobe |
| mem_addr | output | AW | Byte address of the word write |
| mem_data | output | W | Word written |
| ev_mask | input | 4 | Interrupt mask per event bit |
| ev_clr | input | 4 | Write-one-to-clear strobes for event bits |
| ev | output | 4 | Event bits: 0 closed, 1 word stored, 2 busy, 3 overrun |
| irq | output | 1 | Masked event interrupt |

## Verification
Two collisions need care. A word can complete while the FIFO is full and in the same cycle the head word is granted out. The bench provokes this directly: it fills the FIFO with the grant held low, then raises the grant exactly on the sixteenth bit. It then expects the word-stored event and no overrun. An event can also be set in the same cycle that software clears it. The bench pulses ev_clr with all ones during a granted write and expects the word-stored bit to survive while the other bits clear. Random phases with varied valid, grant and ready rates produce both collisions many more times, and a cycle-level model of the requirements judges each one.

// File: rtl/tsr_rx.sv
module tsr_rx #(
  parameter int W     = 16,
  parameter int AW    = 16,
  parameter int LW    = 12,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_valid,
  input  logic          rx_bit,
  input  logic [LW-1:0] max_len,
  input  logic          desc_ready,
  input  logic          desc_intr,
  input  logic [AW-1:0] desc_addr,
  output logic          desc_done,
  output logic          svc_req,
  input  logic          mem_grant,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_data,
  input  logic [3:0]    ev_mask,
  input  logic [3:0]    ev_clr,
  output logic [3:0]    ev,
  output logic          irq
);
  localparam int CW = $clog2(W);
  localparam int FW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  sh;
  logic [CW-1:0] bitcnt;
  logic [W-1:0]  fifo [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [FW-1:0] fill;
  logic [LW-1:0] wcnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire          take      = rx_en & rx_valid;
  wire          word_done = take && (bitcnt == CW'(W - 1));
  wire [W-1:0]  word      = {sh[W-2:0], rx_bit};
  wire          full      = (fill == FW'(DEPTH));
  wire          pop       = mem_grant && (fill != '0);
  wire          push      = word_done && (!full || pop);
  wire          ovr       = word_done && full && !pop;
  wire          busy      = pop && !desc_ready;
  wire [LW:0]   nbytes    = {wcnt, 1'b0} + (LW+1)'(2);
  wire          last      = (nbytes == {1'b0, max_len});

  assign svc_req   = (fill != '0);
  assign mem_wr    = pop && desc_ready;
  assign mem_data  = fifo[rp];
  assign mem_addr  = desc_addr + AW'({wcnt, 1'b0});
  assign desc_done = mem_wr && last;
  assign irq       = |(ev & ev_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      bitcnt <= '0;
    end else if (take) begin
      sh     <= word;
      bitcnt <= word_done ? '0 : bitcnt + 1'b1;
    end else if (!rx_en) begin
      bitcnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo[wp] <= word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp   <= '0;
      wp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      fill <= fill + FW'(push) - FW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      wcnt <= '0;
    else if (mem_wr) wcnt <= last ? '0 : wcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ev <= '0;
    else        ev <= (ev & ~ev_clr) | {ovr, busy, mem_wr, desc_done & desc_intr};
  end
endmodule

// File: rtl/tsr_rx_chk.sv
module tsr_rx_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_en,
  input logic                       mem_grant,
  input logic                       desc_ready,
  input logic                       svc_req,
  input logic                       mem_wr,
  input logic                       desc_done,
  input logic [3:0]                 ev,
  input logic                       irq,
  input logic                       word_done,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic [$clog2(W)-1:0]       bitcnt
);
  a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> bitcnt == '0);
  a_r4_close_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> mem_wr);
  a_r5_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill) <= DEPTH);
  a_r6_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && 32'(fill) == DEPTH && !mem_grant) |=> ev[3]);
  a_r7_write_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> desc_ready);
  a_r7_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && mem_grant && !desc_ready) |=> ev[2]);
  a_r8_rch_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ev[1]);
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ev != 4'b0);
endmodule

bind tsr_rx tsr_rx_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mem_grant(mem_grant),
  .desc_ready(desc_ready), .svc_req(svc_req), .mem_wr(mem_wr),
  .desc_done(desc_done), .ev(ev), .irq(irq), .word_done(word_done),
  .fill(fill), .bitcnt(bitcnt)
);

// File: tb/tsr_rx_test.sv
`timescale 1ns/1ps
module tsr_rx_test;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_en, rx_valid, rx_bit, desc_ready, desc_intr, mem_grant;
  logic [11:0] max_len;
  logic [15:0] desc_addr;
  logic [3:0]  ev_mask, ev_clr;
  logic        desc_done, svc_req, mem_wr, irq;
  logic [15:0] mem_addr, mem_data;
  logic [3:0]  ev;

  always #2 clk = ~clk;

  tsr_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .max_len(max_len), .desc_ready(desc_ready), .desc_intr(desc_intr),
    .desc_addr(desc_addr), .desc_done(desc_done), .svc_req(svc_req),
    .mem_grant(mem_grant), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_data(mem_data),
    .ev_mask(ev_mask), .ev_clr(ev_clr), .ev(ev), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] m_sh;
  int          m_cnt, m_wc;
  logic [15:0] m_q[$];
  logic [3:0]  m_ev;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_irq(input logic [3:0] e, input logic [3:0] m);
    return |(e & m);
  endfunction

  task automatic tick();
    bit p, wr, bsy, dn, wd, ovr;
    #1;
    p   = mem_grant && (m_q.size() > 0);
    wr  = p && desc_ready;
    bsy = p && !desc_ready;
    dn  = wr && (2 * (m_wc + 1) == int'(max_len));
    check(svc_req == (m_q.size() > 0), "R5", "svc_req", svc_req, m_q.size() > 0);
    check(mem_wr == wr, "R7", "mem_wr", mem_wr, wr);
    check(ev == m_ev, "R8", "ev", ev, m_ev);
    check(irq == exp_irq(m_ev, ev_mask), "R9", "irq", irq, exp_irq(m_ev, ev_mask));
    if (wr) begin
      check(mem_data == m_q[0], "R2", "mem_data", mem_data, m_q[0]);
      check(mem_addr == desc_addr + 16'(2 * m_wc), "R3", "mem_addr", mem_addr,
            desc_addr + 16'(2 * m_wc));
      check(desc_done == dn, "R4", "desc_done", desc_done, dn);
    end else begin
      check(desc_done == 1'b0, "R4", "desc_done idle", desc_done, 0);
    end
    wd = 0;
    if (rx_en && rx_valid) begin
      m_sh = {m_sh[14:0], rx_bit};
      m_cnt++;
      if (m_cnt == 16) begin wd = 1; m_cnt = 0; end
    end else if (!rx_en) begin
      m_cnt = 0;
    end
    if (p) void'(m_q.pop_front());
    ovr = 0;
    if (wd) begin
      if (m_q.size() < 3) m_q.push_back(m_sh);
      else ovr = 1;
    end
    if (wr) m_wc = dn ? 0 : m_wc + 1;
    m_ev = (m_ev & ~ev_clr) | {ovr, bsy, wr, dn && desc_intr};
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [11:0] len);
    rst_n = 0; rx_en = 0; rx_valid = 0; rx_bit = 0; desc_ready = 1; desc_intr = 0;
    mem_grant = 0; ev_mask = 4'hF; ev_clr = 0; max_len = len;
    desc_addr = 16'($urandom) & 16'hFFFE;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(svc_req == 0, "R5", "reset svc_req", svc_req, 0);
    check(ev == 0, "R8", "reset ev", ev, 0);
    check(irq == 0, "R9", "reset irq", irq, 0);
    check(mem_wr == 0, "R7", "reset mem_wr", mem_wr, 0);
    m_sh = 0; m_cnt = 0; m_wc = 0; m_q.delete(); m_ev = 0;
    @(negedge clk);
  endtask

  task automatic idle_in();
    rx_valid = 0; mem_grant = 0; ev_clr = 0; desc_ready = 1;
  endtask

  task automatic run(input int n, input int pv, input int pg, input int pr);
    for (int i = 0; i < n; i++) begin
      rx_en      = ($urandom % 100) < 97;
      rx_valid   = ($urandom % 100) < pv;
      rx_bit     = $urandom;
      mem_grant  = ($urandom % 100) < pg;
      desc_ready = ($urandom % 100) < pr;
      desc_intr  = $urandom;
      ev_clr     = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      ev_mask    = 4'($urandom);
      tick();
    end
  endtask

  task automatic feed(input logic [15:0] pat, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      rx_en = 1; rx_valid = 1; rx_bit = pat[15 - (i % 16)];
      tick();
    end
    rx_valid = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    do_reset(12'd4);
    desc_intr = 1;
    // R2: MSB first, residue held
    feed(16'hA5C3, 16);
    feed(16'hFFFF, 5);
    idle_in(); mem_grant = 1; tick();
    mem_grant = 0; tick(); tick();
    check(svc_req == 0, "R2", "residue not emitted", svc_req, 0);
    // R1: bits ignored when disabled
    rx_en = 0; rx_valid = 1;
    for (int i = 0; i < 40; i++) begin rx_bit = $urandom; tick(); end
    check(svc_req == 0, "R1", "disabled bits ignored", svc_req, 0);
    // R6: completion on the same cycle as a pop from a full FIFO
    idle_in(); ev_clr = 4'hF; tick(); ev_clr = 0;
    feed(16'h1234, 48);
    feed(16'h5678, 15);
    rx_valid = 1; rx_bit = 1'b0; mem_grant = 1; tick();
    idle_in(); tick();
    check(ev[3] == 0, "R6", "no overrun on pop", ev[3], 0);
    check(ev[1] == 1, "R8", "word stored event", ev[1], 1);
    feed(16'h9ABC, 16);
    idle_in(); tick();
    check(ev[3] == 1, "R6", "overrun when full", ev[3], 1);
    // R8: set wins over clear in the same cycle
    ev_clr = 4'hF; mem_grant = 1; tick();
    idle_in(); tick();
    check(ev == 4'b0010, "R8", "set beats clear", ev, 4'b0010);
    // R7: busy when no buffer
    desc_ready = 0; mem_grant = 1; tick();
    idle_in(); tick();
    check(ev[2] == 1, "R7", "busy event", ev[2], 1);
    // random phases
    do_reset(12'd8);  run(3000, 70, 30, 90);
    do_reset(12'd2);  run(3000, 90, 20, 80);
    do_reset(12'd6);  run(3000, 50, 60, 95);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule